// File: doc/BRIEF.md
# DS3 Transmit Frame Reference Generator

This block supplies reference timing to a bit-serial DS3 transmitter. It runs from a free-running 44.736 MHz clock and forwards that clock as its timing output. A DS3 frame is 4760 bit periods long. It is split into 7 subframes, and each subframe holds 8 groups of 85 bits. The first bit of every group is an overhead position.

The block counts through the frame and drives three signals. An active-low strobe marks the start of the frame. A second active-low strobe marks the overhead bit of every group. A serial reference stream carries the framing pattern only: the F bits and the M bits. Every other bit period, whether payload or any other overhead, is driven low. A downstream transmitter aligns its own frame to these strobes.

Control is a small state machine with three states:
- `ST_HALT` is held while reset is asserted.
- `ST_OVH` is the overhead bit period of a group.
- `ST_PAY` covers the 84 payload bit periods of a group.

It has four transitions:
- `HALT->OVH`: the first clock with reset low.
- `OVH->PAY`: always, after one bit period.
- `PAY->PAY`: while the group is not finished.
- `PAY->OVH`: on the last payload bit of the group.

Reset is synchronous and forces `ST_HALT` from any state. Three cascaded modulo counters track the bit within the group, the group within the subframe, and the subframe within the frame.

Top module: `ds3_tx_ref_gen`

## Requirements
- R1: While reset is sampled high, the outputs are inactive on the next cycle and stay inactive: `frame_n_o`=1, `gap_n_o`=1, `data_o`=0.
- R2: The first clock edge with reset low starts frame bit 1. During the cycle after that edge, `frame_n_o` and `gap_n_o` are both low.
- R3: `gap_n_o` is low for exactly one clock at bit 1 of every 85-bit group. Consecutive pulses are 85 clocks apart, giving 56 pulses per frame.
- R4: `frame_n_o` is low for exactly one clock. Consecutive pulses are 4760 clocks apart, and each pulse falls in the same cycle as a `gap_n_o` pulse.
- R5: In every subframe, `data_o` carries the F bits at bit 1 of groups 2, 4, 6 and 8, with values 1, 0, 0, 1 in that order.
- R6: At bit 1 of group 1 of subframes 5, 6 and 7, `data_o` carries the M bits 0, 1, 0.
- R7: `data_o` is 0 at every other position: all payload bits and all other overhead bits. This gives exactly 15 ones per frame.
- R8: `ref_clk_o` follows `clk_i` level for level.
- R9: Reset applied in the middle of a frame abandons the current position. After release, output restarts at frame bit 1 with the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 44.736 MHz reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_clk_o | output | 1 | Forwarded reference clock |
| frame_n_o | output | 1 | Active-low strobe at frame bit 1 |
| gap_n_o | output | 1 | Active-low strobe at bit 1 of each 85-bit group |
| data_o | output | 1 | Framing-only reference data (M and F bits, otherwise 0) |

## Verification
The frame strobe and the group strobe fall in the same cycle at frame bit 1. An M-bit position also meets a gap strobe at the start of subframes 5 to 7. Both of these coincidences are checked every cycle against a bench model of frame position.

Random mid-frame resets, at lengths drawn from a fixed seed, land the restart on arbitrary group and subframe boundaries. The bench then judges that the next frame strobe is exactly one cycle after release, and that both strobe spacings hold again from that point.

// File: rtl/ds3r_pkg.sv
package ds3r_pkg;

    // Frame geometry
    localparam int unsigned GROUP_LEN_DEF = 85;
    localparam int unsigned GROUPS_DEF    = 8;
    localparam int unsigned SUBFRAMES_DEF = 7;

    // Framing values, first transmitted bit in the MSB
    localparam logic [3:0] F_PAT_DEF = 4'b1001;
    localparam logic [2:0] M_PAT_DEF = 3'b010;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_OVH  = 2'd1,
        ST_PAY  = 2'd2
    } ref_state_e;

endpackage

// File: rtl/ds3r_mod_ctr.sv
module ds3r_mod_ctr #(
    parameter int unsigned MOD = 85,
    localparam int unsigned W  = (MOD > 1) ? $clog2(MOD) : 1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    output logic [W-1:0] count_o,
    output logic         last_o
);

    localparam logic [W-1:0] LAST_VAL = W'(MOD - 1);

    logic [W-1:0] count_q;

    assign last_o  = (count_q == LAST_VAL);
    assign count_o = count_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            count_q <= '0;
        end else if (en_i) begin
            count_q <= last_o ? '0 : count_q + W'(1);
        end
    end

endmodule

// File: rtl/ds3r_ovh_map.sv
module ds3r_ovh_map #(
    parameter int unsigned GROUPS    = 8,
    parameter int unsigned SUBFRAMES = 7,
    parameter logic [GROUPS/2-1:0] F_PAT = 4'b1001,
    parameter logic [2:0]          M_PAT = 3'b010,
    localparam int unsigned GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int unsigned SW = (SUBFRAMES > 1) ? $clog2(SUBFRAMES) : 1
) (
    input  logic [GW-1:0] grp_i,
    input  logic [SW-1:0] sub_i,
    output logic          bit_o
);

    localparam int unsigned NF      = GROUPS / 2;
    localparam int unsigned M_FIRST = SUBFRAMES - 3;

    always_comb begin
        int unsigned g;
        int unsigned s;
        g     = int'(grp_i);
        s     = int'(sub_i);
        bit_o = 1'b0;
        if (g[0]) begin
            // odd group index carries an F bit
            bit_o = F_PAT[NF - 1 - (g >> 1)];
        end else if (g == 0 && s >= M_FIRST) begin
            bit_o = M_PAT[2 - (s - M_FIRST)];
        end
    end

endmodule

// File: rtl/ds3_tx_ref_gen.sv
module ds3_tx_ref_gen #(
    parameter int unsigned GROUP_LEN = ds3r_pkg::GROUP_LEN_DEF,
    parameter int unsigned GROUPS    = ds3r_pkg::GROUPS_DEF,
    parameter int unsigned SUBFRAMES = ds3r_pkg::SUBFRAMES_DEF,
    parameter logic [3:0]  F_PAT     = ds3r_pkg::F_PAT_DEF,
    parameter logic [2:0]  M_PAT     = ds3r_pkg::M_PAT_DEF
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic ref_clk_o,
    output logic frame_n_o,
    output logic gap_n_o,
    output logic data_o
);

    import ds3r_pkg::*;

    localparam int unsigned BW = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;
    localparam int unsigned GW = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int unsigned SW = (SUBFRAMES > 1) ? $clog2(SUBFRAMES) : 1;

    ref_state_e st_q, st_d;

    logic          run;
    logic [BW-1:0] bit_idx;
    logic [GW-1:0] grp_idx;
    logic [SW-1:0] sub_idx;
    logic          bit_last, grp_last, sub_last;
    logic          ovh_bit;

    assign run       = (st_q != ST_HALT);
    assign ref_clk_o = clk_i;

    // Position counters: bit in group, group in subframe, subframe in frame
    ds3r_mod_ctr #(.MOD(GROUP_LEN)) u_bit_ctr (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (run),
        .count_o(bit_idx),
        .last_o (bit_last)
    );

    ds3r_mod_ctr #(.MOD(GROUPS)) u_grp_ctr (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (run & bit_last),
        .count_o(grp_idx),
        .last_o (grp_last)
    );

    ds3r_mod_ctr #(.MOD(SUBFRAMES)) u_sub_ctr (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (run & bit_last & grp_last),
        .count_o(sub_idx),
        .last_o (sub_last)
    );

    ds3r_ovh_map #(
        .GROUPS   (GROUPS),
        .SUBFRAMES(SUBFRAMES),
        .F_PAT    (F_PAT),
        .M_PAT    (M_PAT)
    ) u_map (
        .grp_i(grp_idx),
        .sub_i(sub_idx),
        .bit_o(ovh_bit)
    );

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= ST_HALT;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT: st_d = ST_OVH;
            ST_OVH:  st_d = (GROUP_LEN > 1) ? ST_PAY : ST_OVH;
            ST_PAY:  st_d = bit_last ? ST_OVH : ST_PAY;
            default: st_d = ST_HALT;
        endcase
    end

    // Outputs
    always_comb begin
        frame_n_o = 1'b1;
        gap_n_o   = 1'b1;
        data_o    = 1'b0;
        unique case (st_q)
            ST_HALT: begin
                frame_n_o = 1'b1;
            end
            ST_OVH: begin
                gap_n_o   = 1'b0;
                frame_n_o = !(grp_idx == '0 && sub_idx == '0);
                data_o    = ovh_bit;
            end
            ST_PAY: begin
                data_o = 1'b0;
            end
            default: begin
                frame_n_o = 1'b1;
            end
        endcase
    end

    logic unused_sub_last;
    assign unused_sub_last = sub_last;

endmodule

// File: rtl/ds3_tx_ref_gen_chk.sv
module ds3_tx_ref_gen_chk #(
    parameter int unsigned GROUP_LEN = ds3r_pkg::GROUP_LEN_DEF,
    parameter int unsigned GROUPS    = ds3r_pkg::GROUPS_DEF,
    parameter int unsigned SUBFRAMES = ds3r_pkg::SUBFRAMES_DEF
) (
    input logic clk_i,
    input logic rst_i,
    input logic frame_n_o,
    input logic gap_n_o,
    input logic data_o
);

    localparam int unsigned FRAME_LEN = GROUP_LEN * GROUPS * SUBFRAMES;
    localparam int unsigned CW = $clog2(FRAME_LEN + 1);

    logic [CW-1:0] gap_cnt, frm_cnt;
    logic          gap_seen, frm_seen;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gap_cnt  <= '0;
            frm_cnt  <= '0;
            gap_seen <= 1'b0;
            frm_seen <= 1'b0;
        end else begin
            if (!gap_n_o) begin
                gap_cnt  <= '0;
                gap_seen <= 1'b1;
            end else if (gap_cnt != {CW{1'b1}}) begin
                gap_cnt <= gap_cnt + CW'(1);
            end
            if (!frame_n_o) begin
                frm_cnt  <= '0;
                frm_seen <= 1'b1;
            end else if (frm_cnt != {CW{1'b1}}) begin
                frm_cnt <= frm_cnt + CW'(1);
            end
        end
    end

    a_r2_first_frame: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(rst_i) && !rst_i) |=> !frame_n_o);

    a_r3_gap_spacing: assert property (@(posedge clk_i) disable iff (rst_i)
        (gap_seen && !gap_n_o) |-> (gap_cnt == CW'(GROUP_LEN - 1)));

    a_r3_gap_width: assert property (@(posedge clk_i) disable iff (rst_i)
        (!gap_n_o && GROUP_LEN > 1) |=> gap_n_o);

    a_r4_frame_spacing: assert property (@(posedge clk_i) disable iff (rst_i)
        (frm_seen && !frame_n_o) |-> (frm_cnt == CW'(FRAME_LEN - 1)));

    a_r4_frame_in_gap: assert property (@(posedge clk_i) disable iff (rst_i)
        !frame_n_o |-> !gap_n_o);

    a_r7_data_only_overhead: assert property (@(posedge clk_i) disable iff (rst_i)
        data_o |-> !gap_n_o);

endmodule

bind ds3_tx_ref_gen ds3_tx_ref_gen_chk #(
    .GROUP_LEN(GROUP_LEN),
    .GROUPS   (GROUPS),
    .SUBFRAMES(SUBFRAMES)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .frame_n_o(frame_n_o),
    .gap_n_o  (gap_n_o),
    .data_o   (data_o)
);

// File: tb/ds3_tx_ref_gen_tb.sv
module ds3_tx_ref_gen_tb;

    localparam int FLEN = 4760;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_clk, frame_n, gap_n, data;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    // bench model of position
    bit run         = 0;
    int pos         = 0;
    bit after_mid   = 0;
    int last_gap    = -1;
    int last_frm    = -1;
    int ones_in_frm = 0;

    always #10 clk = ~clk;

    ds3_tx_ref_gen u_dut (
        .clk_i    (clk),
        .rst_i    (rst),
        .ref_clk_o(ref_clk),
        .frame_n_o(frame_n),
        .gap_n_o  (gap_n),
        .data_o   (data)
    );

    function automatic bit exp_data(input int p);
        int b, g, s;
        bit [3:0] fp;
        bit [2:0] mp;
        fp = 4'b1001;
        mp = 3'b010;
        b = p % 85;
        g = (p / 85) % 8;
        s = p / 680;
        if (b != 0) return 1'b0;
        if (g % 2 == 1) return fp[3 - g / 2];
        if (g == 0 && s >= 4) return mp[2 - (s - 4)];
        return 1'b0;
    endfunction

    function automatic string data_req(input int p);
        int b, g, s;
        b = p % 85;
        g = (p / 85) % 8;
        s = p / 680;
        if (b == 0 && g % 2 == 1) return "R5";
        if (b == 0 && g == 0 && s >= 4) return "R6";
        return "R7";
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d cycle=%0d pos=%0d", req, act, exp, cycles, pos);
        end
    endtask

    // Model update at the active edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            run = 0;
            pos = 0;
        end else if (!run) begin
            run = 1;
            pos = 0;
            last_gap = -1;
            last_frm = -1;
            ones_in_frm = 0;
        end else begin
            pos = (pos + 1) % FLEN;
        end
    end

    // Output comparison away from the edge
    always @(negedge clk) begin
        if (!done) begin
            chk("R8", ref_clk, 0);
            if (!run) begin
                chk("R1", frame_n, 1);
                chk("R1", gap_n, 1);
                chk("R1", data, 0);
            end else begin
                if (pos == 0) begin
                    if (last_frm < 0) chk(after_mid ? "R9" : "R2", frame_n, 0);
                    else chk("R4", frame_n, 0);
                end else begin
                    chk("R4", frame_n, 1);
                end
                chk("R3", gap_n, (pos % 85 == 0) ? 0 : 1);
                chk(data_req(pos), data, exp_data(pos));
                if (!gap_n) begin
                    if (last_gap >= 0) chk("R3", cycles - last_gap, 85);
                    last_gap = cycles;
                end
                if (!frame_n) begin
                    if (last_frm >= 0) begin
                        chk("R4", cycles - last_frm, FLEN);
                        chk("R7", ones_in_frm, 15);
                    end
                    last_frm = cycles;
                    ones_in_frm = 0;
                end
                if (data) ones_in_frm++;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (!done && cycles > 150000) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h00D5_3A11);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R8: forwarded clock high while input clock is high
        repeat (3) begin
            @(posedge clk);
            #3;
            chk("R8", ref_clk, 1);
        end
        @(negedge clk);
        rst = 1'b0;
        // two full frames and change
        repeat (2 * FLEN + 20) @(negedge clk);
        // directed mid-frame reset in the last payload bit of a group
        while (pos % 85 != 84) @(negedge clk);
        rst = 1'b1;
        after_mid = 1;
        @(negedge clk);
        rst = 1'b0;
        repeat (FLEN + 100) @(negedge clk);
        // random mid-frame resets
        for (int i = 0; i < 4; i++) begin
            repeat (100 + ($urandom % 3000)) @(negedge clk);
            rst = 1'b1;
            repeat (1 + ($urandom % 4)) @(negedge clk);
            rst = 1'b0;
            repeat (200 + ($urandom % 2000)) @(negedge clk);
        end
        // a last reset landing exactly on an overhead bit
        while (pos % 85 != 0) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (FLEN + 10) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule